// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional Pairs

This block sits beside a shared memory write port and decides, for several requesters, whether each store-conditional may write. Every requester holds at most one reservation: a valid flag and the granule it covers. A load-reserved sets that reservation. The data read for a load-reserved is served by the memory read path, outside this block. A store-conditional passes only if the requester's reservation is still intact. A passing store is forwarded to the memory write port. A failing one writes nothing.

A reservation is lost for any of these reasons:
- any write lands anywhere in its granule, whatever value the write carries;
- the requester's clear input is pulsed, for example on an exception or a context switch;
- the requester issues another load-reserved, which replaces the old one;
- the requester issues a store-conditional of its own.

The granule is a power of two, from 8 to 2048 bytes. Only one reservation exists per requester, so reservations never nest. A single write port serves all requesters, so at most one store-conditional can pass in any cycle.

Top module: `llsc_monitor`

## Requirements
- R1: A load-reserved (op bit 0) records a reservation on the addressed granule for the issuing requester, and its response reports rsp_fail = 0.
- R2: A store-conditional (op bit 1) passes when all of the following hold: the issuer holds a valid reservation, the reservation covers the granule of the store address, and no write has reached that granule since the reservation was set. A passing store drives mem_wr_valid one clock later, with the store's address, data and requester index.
- R3: Any write on the snoop input to any byte of a reserved granule drops that reservation. This holds even when the write restores the value that was loaded.
- R4: Two addresses belong to the same granule when they differ only in their low log2(GRANULE_BYTES) bits. A store-conditional whose address lies outside the reserved granule fails and writes nothing.
- R5: A new load-reserved replaces the issuer's existing reservation. A later store-conditional to the old granule fails.
- R6: Pulsing resv_clear[i] drops requester i's reservation, so its next store-conditional fails.
- R7: A store-conditional drops the issuer's reservation whether it passes or fails. A second store-conditional right after it fails.
- R8: A passing store-conditional drops the reservation of every other requester on the same granule, in the same cycle.
- R9: At most one store-conditional passes per cycle. Among the eligible requesters, the lowest index wins and every other store-conditional fails.
- R10: Every request gets rsp_valid exactly one clock later. rsp_fail = 0 means success and rsp_fail = 1 means failure. Only a store-conditional can report failure.
- R11: Reset clears every reservation and every output. A store-conditional issued after reset with no load-reserved fails.
- R12: Events that arrive in the same cycle as a request are ordered as follows. A clear or a snoop write to the granule makes a store-conditional in that cycle fail. A load-reserved in the same cycle as a write to its granule ends with no reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NUM_AGENTS | Request strobe, one bit per requester |
| req_op | input | NUM_AGENTS | 0 = load-reserved, 1 = store-conditional |
| req_addr | input | NUM_AGENTS*ADDR_W | Byte address; requester i uses slice i |
| req_data | input | NUM_AGENTS*DATA_W | Store data; requester i uses slice i |
| resv_clear | input | NUM_AGENTS | Drops the reservation of requester i |
| snoop_valid | input | 1 | An ordinary write is taking place on the shared bus |
| snoop_addr | input | ADDR_W | Byte address of the snooped write |
| rsp_valid | output | NUM_AGENTS | Response strobe, one clock after the request |
| rsp_fail | output | NUM_AGENTS | 0 = success, 1 = store-conditional failed |
| mem_wr_valid | output | 1 | Forwarded write from a passing store-conditional |
| mem_wr_addr | output | ADDR_W | Address of the forwarded write |
| mem_wr_data | output | DATA_W | Data of the forwarded write |
| mem_wr_id | output | ID_W | Index of the requester that won |

## Verification
The bench builds the block with three requesters, 8-byte granules, 12-bit addresses and 16-bit data, and draws random addresses from only eight granules. This makes snoop hits, requesters that share a granule, and same-cycle contention between store-conditionals frequent. The smallest granule size puts the byte-offset boundary (offset 7 against offset 8) within reach. Three requesters give a fixed-priority case with a middle index that must both win and lose.

// File: rtl/llsc_pkg.sv
// Package: shared types for the reservation monitor.
// Assumes: one op bit per request selects between the two operations.
package llsc_pkg;

    typedef enum logic {
        OP_LR = 1'b0,
        OP_SC = 1'b1
    } llsc_op_e;

endpackage

// File: rtl/llsc_resv_slot.sv
// Module: one requester's reservation register (valid flag + granule).
// Assumes granule numbers are already shifted right by log2(granule size).
// Update order within a cycle: set by load-reserved, then kills by own
// store-conditional, by snoop writes, by the forwarded winner write, and
// last by clear. So a write that arrives with a load-reserved leaves it
// unset, and clear always wins.
module llsc_resv_slot #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              set_i,
    input  logic [ADDR_W-1:0] set_gran_i,
    input  logic              self_kill_i,
    input  logic              snoop_v_i,
    input  logic [ADDR_W-1:0] snoop_gran_i,
    input  logic              wr_v_i,
    input  logic [ADDR_W-1:0] wr_gran_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] gran_o
);

    logic              valid_q;
    logic [ADDR_W-1:0] gran_q;
    logic              nxt_valid;
    logic [ADDR_W-1:0] nxt_gran;

    // Next-state: apply set first, then every kill source in order.
    always_comb begin
        nxt_valid = valid_q;
        nxt_gran  = gran_q;
        if (set_i) begin
            nxt_valid = 1'b1;
            nxt_gran  = set_gran_i;
        end
        if (self_kill_i) begin
            nxt_valid = 1'b0;
        end
        if (snoop_v_i && (snoop_gran_i == nxt_gran)) begin
            nxt_valid = 1'b0;
        end
        if (wr_v_i && (wr_gran_i == nxt_gran)) begin
            nxt_valid = 1'b0;
        end
        if (clear_i) begin
            nxt_valid = 1'b0;
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            gran_q  <= '0;
        end else begin
            valid_q <= nxt_valid;
            gran_q  <= nxt_gran;
        end
    end

    assign valid_o = valid_q;
    assign gran_o  = gran_q;

endmodule

// File: rtl/llsc_sc_arbiter.sv
// Module: fixed-priority picker for the single memory write port.
// Assumes: requester 0 has the highest priority; the result is combinational.
module llsc_sc_arbiter #(
    parameter int NUM_AGENTS = 4,
    parameter int ID_W       = 2
) (
    input  logic [NUM_AGENTS-1:0] eligible_i,
    output logic [NUM_AGENTS-1:0] grant_o,
    output logic                  found_o,
    output logic [ID_W-1:0]       win_id_o
);

    // Scan from the highest index down so the lowest eligible index is kept.
    always_comb begin
        grant_o  = '0;
        found_o  = 1'b0;
        win_id_o = '0;
        for (int i = NUM_AGENTS - 1; i >= 0; i--) begin
            if (eligible_i[i]) begin
                grant_o  = '0;
                grant_o[i] = 1'b1;
                found_o  = 1'b1;
                win_id_o = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/llsc_monitor.sv
// Module: reservation monitor for load-reserved / store-conditional pairs.
// Holds one reservation per requester at GRANULE_BYTES granularity.
// Decides pass/fail for each store-conditional and forwards at most one
// passing store per cycle. Responses and the forwarded write are registered
// and appear one clock after the request.
// Assumes GRANULE_BYTES is a power of two in 8..2048, and that requests are
// single-cycle strobes with no back-pressure.
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NUM_AGENTS    = 4,
    parameter int ADDR_W        = 32,
    parameter int DATA_W        = 32,
    parameter int GRANULE_BYTES = 64,
    parameter int ID_W          = (NUM_AGENTS > 1) ? $clog2(NUM_AGENTS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_AGENTS-1:0]        req_valid,
    input  logic [NUM_AGENTS-1:0]        req_op,
    input  logic [NUM_AGENTS*ADDR_W-1:0] req_addr,
    input  logic [NUM_AGENTS*DATA_W-1:0] req_data,
    input  logic [NUM_AGENTS-1:0]        resv_clear,
    input  logic                         snoop_valid,
    input  logic [ADDR_W-1:0]            snoop_addr,
    output logic [NUM_AGENTS-1:0]        rsp_valid,
    output logic [NUM_AGENTS-1:0]        rsp_fail,
    output logic                         mem_wr_valid,
    output logic [ADDR_W-1:0]            mem_wr_addr,
    output logic [DATA_W-1:0]            mem_wr_data,
    output logic [ID_W-1:0]              mem_wr_id
);

    localparam int GRAN_LOG2 = $clog2(GRANULE_BYTES);

    logic [ADDR_W-1:0]     agent_addr [NUM_AGENTS];
    logic [ADDR_W-1:0]     agent_gran [NUM_AGENTS];
    logic [DATA_W-1:0]     agent_data [NUM_AGENTS];
    logic [ADDR_W-1:0]     slot_gran  [NUM_AGENTS];
    logic [NUM_AGENTS-1:0] slot_valid;
    logic [NUM_AGENTS-1:0] is_lr;
    logic [NUM_AGENTS-1:0] is_sc;
    logic [NUM_AGENTS-1:0] eligible;
    logic [NUM_AGENTS-1:0] grant;
    logic                  win_found;
    logic [ID_W-1:0]       win_id;
    logic [ADDR_W-1:0]     snoop_gran;
    logic [ADDR_W-1:0]     win_addr;
    logic [ADDR_W-1:0]     win_gran;
    logic [DATA_W-1:0]     win_data;

    // Granule number of the snooped write.
    assign snoop_gran = snoop_addr >> GRAN_LOG2;

    for (genvar g = 0; g < NUM_AGENTS; g++) begin : g_agent
        // Per-requester decode of op, address slice, data slice and granule.
        assign agent_addr[g] = req_addr[g*ADDR_W +: ADDR_W];
        assign agent_data[g] = req_data[g*DATA_W +: DATA_W];
        assign agent_gran[g] = agent_addr[g] >> GRAN_LOG2;
        assign is_lr[g]      = req_valid[g] && (llsc_op_e'(req_op[g]) == OP_LR);
        assign is_sc[g]      = req_valid[g] && (llsc_op_e'(req_op[g]) == OP_SC);

        // Eligible: intact reservation on this granule, not killed this cycle.
        assign eligible[g] = is_sc[g] && slot_valid[g]
                           && (slot_gran[g] == agent_gran[g])
                           && !resv_clear[g]
                           && !(snoop_valid && (snoop_gran == slot_gran[g]));

        llsc_resv_slot #(
            .ADDR_W (ADDR_W)
        ) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .clear_i      (resv_clear[g]),
            .set_i        (is_lr[g]),
            .set_gran_i   (agent_gran[g]),
            .self_kill_i  (is_sc[g]),
            .snoop_v_i    (snoop_valid),
            .snoop_gran_i (snoop_gran),
            .wr_v_i       (win_found),
            .wr_gran_i    (win_gran),
            .valid_o      (slot_valid[g]),
            .gran_o       (slot_gran[g])
        );
    end

    llsc_sc_arbiter #(
        .NUM_AGENTS (NUM_AGENTS),
        .ID_W       (ID_W)
    ) u_arb (
        .eligible_i (eligible),
        .grant_o    (grant),
        .found_o    (win_found),
        .win_id_o   (win_id)
    );

    // Select the winner's address, data and granule for forwarding and kill.
    assign win_addr = agent_addr[win_id];
    assign win_data = agent_data[win_id];
    assign win_gran = agent_gran[win_id];

    // Register the responses and the forwarded write (one-clock latency).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= '0;
            rsp_fail     <= '0;
            mem_wr_valid <= 1'b0;
            mem_wr_addr  <= '0;
            mem_wr_data  <= '0;
            mem_wr_id    <= '0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_fail     <= is_sc & ~grant;
            mem_wr_valid <= win_found;
            mem_wr_addr  <= win_found ? win_addr : '0;
            mem_wr_data  <= win_found ? win_data : '0;
            mem_wr_id    <= win_found ? win_id : '0;
        end
    end

endmodule

// File: rtl/llsc_monitor_chk.sv
// Module: property checker for llsc_monitor, bound to every instance.
// Assumes: it sees only the top-level ports, plus one register of its own.
module llsc_monitor_chk #(
    parameter int NUM_AGENTS = 4,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int GRAN_LOG2  = 6,
    parameter int ID_W       = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_AGENTS-1:0]        req_valid,
    input logic [NUM_AGENTS-1:0]        req_op,
    input logic [NUM_AGENTS*ADDR_W-1:0] req_addr,
    input logic [NUM_AGENTS-1:0]        resv_clear,
    input logic                         snoop_valid,
    input logic [ADDR_W-1:0]            snoop_addr,
    input logic [NUM_AGENTS-1:0]        rsp_valid,
    input logic [NUM_AGENTS-1:0]        rsp_fail,
    input logic                         mem_wr_valid,
    input logic [ID_W-1:0]              mem_wr_id
);

    logic [NUM_AGENTS-1:0] sc_q;
    logic [NUM_AGENTS-1:0] succ;

    // Remember which requests were store-conditionals, for response checks.
    always_ff @(posedge clk) begin
        if (!rst_n) sc_q <= '0;
        else        sc_q <= req_valid & req_op;
    end

    assign succ = rsp_valid & ~rsp_fail & sc_q;

    // R9: never more than one store-conditional passes in a cycle.
    assert_one_success_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(succ));

    // R2: a forwarded write appears exactly when a store-conditional passed.
    assert_write_on_success_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid == (|succ));

    // R11: while reset is low, the next cycle shows idle outputs.
    assert_reset_idle_R11: assert property (@(posedge clk)
        !rst_n |=> (rsp_valid == '0) && !mem_wr_valid && (mem_wr_id == '0));

    for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_prop
        // R10: each request is answered one clock later, and only then.
        assert_resp_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid[i] |=> rsp_valid[i]);
        assert_no_spurious_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid[i] |=> !rsp_valid[i]);

        // R1: a load-reserved never reports failure.
        assert_lr_never_fails_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[i] && !req_op[i]) |=> !rsp_fail[i]);

        // R6 / R12: a clear in the same cycle as a store-conditional makes it fail.
        assert_clear_fails_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[i] && req_op[i] && resv_clear[i]) |=> rsp_fail[i]);

        // R12: a snoop write to the same granule in the same cycle makes it fail.
        assert_snoop_same_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[i] && req_op[i] && snoop_valid
             && ((req_addr[i*ADDR_W +: ADDR_W] >> GRAN_LOG2) == (snoop_addr >> GRAN_LOG2)))
            |=> rsp_fail[i]);

        // R7: two back-to-back store-conditionals: the second one fails.
        assert_sc_twice_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[i] && req_op[i]) ##1 (req_valid[i] && req_op[i]) |=> rsp_fail[i]);
    end

endmodule

bind llsc_monitor llsc_monitor_chk #(
    .NUM_AGENTS (NUM_AGENTS),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .GRAN_LOG2  ($clog2(GRANULE_BYTES)),
    .ID_W       (ID_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_addr     (req_addr),
    .resv_clear   (resv_clear),
    .snoop_valid  (snoop_valid),
    .snoop_addr   (snoop_addr),
    .rsp_valid    (rsp_valid),
    .rsp_fail     (rsp_fail),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_id    (mem_wr_id)
);

// File: tb/tb_llsc_monitor.sv
// Bench: directed corner cases followed by seeded random traffic. Expected
// values come from a reservation model written from the requirements.
module tb_llsc_monitor;

    localparam int N    = 3;
    localparam int AW   = 12;
    localparam int DW   = 16;
    localparam int GB   = 8;
    localparam int GL   = 3;
    localparam int IDW  = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_valid, req_op, resv_clear;
    logic [N*AW-1:0] req_addr;
    logic [N*DW-1:0] req_data;
    logic            snoop_valid;
    logic [AW-1:0]   snoop_addr;
    logic [N-1:0]    rsp_valid, rsp_fail;
    logic            mem_wr_valid;
    logic [AW-1:0]   mem_wr_addr;
    logic [DW-1:0]   mem_wr_data;
    logic [IDW-1:0]  mem_wr_id;

    logic [AW-1:0] d_addr [N];
    logic [DW-1:0] d_data [N];

    // Model state and pending expectations.
    logic          m_valid [N];
    logic [AW-1:0] m_gran  [N];
    logic [N-1:0]  e_rsp_valid, e_rsp_fail;
    logic          e_mw_valid;
    logic [AW-1:0] e_mw_addr;
    logic [DW-1:0] e_mw_data;
    logic [IDW-1:0] e_mw_id;
    bit            have_exp = 0;
    string         cur_tag = "";
    int            n_checks = 0;
    int            n_err = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            req_addr[i*AW +: AW] = d_addr[i];
            req_data[i*DW +: DW] = d_data[i];
        end
    end

    llsc_monitor #(
        .NUM_AGENTS (N), .ADDR_W (AW), .DATA_W (DW), .GRANULE_BYTES (GB)
    ) dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_op (req_op),
        .req_addr (req_addr), .req_data (req_data), .resv_clear (resv_clear),
        .snoop_valid (snoop_valid), .snoop_addr (snoop_addr),
        .rsp_valid (rsp_valid), .rsp_fail (rsp_fail), .mem_wr_valid (mem_wr_valid),
        .mem_wr_addr (mem_wr_addr), .mem_wr_data (mem_wr_data), .mem_wr_id (mem_wr_id)
    );

    function automatic logic [AW-1:0] gran(input logic [AW-1:0] a);
        return a >> GL;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = '0; req_op = '0; resv_clear = '0;
        snoop_valid = 1'b0; snoop_addr = '0;
        for (int i = 0; i < N; i++) begin d_addr[i] = '0; d_data[i] = '0; end
    endtask

    task automatic lr(input int a, input logic [AW-1:0] addr);
        req_valid[a] = 1'b1; req_op[a] = 1'b0; d_addr[a] = addr;
    endtask

    task automatic sc(input int a, input logic [AW-1:0] addr, input logic [DW-1:0] data);
        req_valid[a] = 1'b1; req_op[a] = 1'b1; d_addr[a] = addr; d_data[a] = data;
    endtask

    // Compare outputs of the previous step, then predict this one and clock.
    task automatic step(input string tag);
        int  win;
        bit  elig;
        logic nv;
        logic [AW-1:0] ng;
        if (have_exp) begin
            check(rsp_valid == e_rsp_valid, "R10", "rsp_valid", rsp_valid, e_rsp_valid);
            check(rsp_fail == e_rsp_fail, cur_tag, "rsp_fail", rsp_fail, e_rsp_fail);
            check(mem_wr_valid == e_mw_valid, "R2", "mem_wr_valid", mem_wr_valid, e_mw_valid);
            if (e_mw_valid) begin
                check(mem_wr_addr == e_mw_addr, "R2", "mem_wr_addr", mem_wr_addr, e_mw_addr);
                check(mem_wr_data == e_mw_data, "R2", "mem_wr_data", mem_wr_data, e_mw_data);
                check(mem_wr_id == e_mw_id, "R9", "mem_wr_id", mem_wr_id, e_mw_id);
            end
        end
        win = -1;
        for (int i = N - 1; i >= 0; i--) begin
            elig = req_valid[i] && req_op[i] && m_valid[i]
                && (m_gran[i] == gran(d_addr[i])) && !resv_clear[i]
                && !(snoop_valid && gran(snoop_addr) == m_gran[i]);
            if (elig) win = i;
        end
        e_rsp_valid = req_valid;
        e_mw_valid  = (win >= 0);
        e_mw_addr   = (win >= 0) ? d_addr[win] : '0;
        e_mw_data   = (win >= 0) ? d_data[win] : '0;
        e_mw_id     = (win >= 0) ? IDW'(win) : '0;
        for (int i = 0; i < N; i++) begin
            e_rsp_fail[i] = req_valid[i] && req_op[i] && (win != i);
            nv = m_valid[i]; ng = m_gran[i];
            if (req_valid[i] && !req_op[i]) begin nv = 1'b1; ng = gran(d_addr[i]); end
            if (req_valid[i] && req_op[i]) nv = 1'b0;
            if (snoop_valid && gran(snoop_addr) == ng) nv = 1'b0;
            if (win >= 0 && gran(d_addr[win]) == ng) nv = 1'b0;
            if (resv_clear[i]) nv = 1'b0;
            m_valid[i] = nv; m_gran[i] = ng;
        end
        cur_tag = tag; have_exp = 1;
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++; n_checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1));
        idle();
        for (int i = 0; i < N; i++) begin m_valid[i] = 1'b0; m_gran[i] = '0; end
        repeat (3) @(negedge clk);
        check(rsp_valid == '0, "R11", "rsp_valid in reset", rsp_valid, 0);
        check(mem_wr_valid == 1'b0, "R11", "mem_wr_valid in reset", mem_wr_valid, 0);
        rst_n = 1'b1;
        // R11: store-conditionals right after reset all fail.
        sc(0, 12'h010, 16'h1); sc(1, 12'h010, 16'h2); sc(2, 12'h020, 16'h3); step("R11");
        // R1 / R2: basic pair passes.
        lr(0, 12'h010); step("R1");
        sc(0, 12'h010, 16'hA5A5); step("R2");
        // R3: write restoring any value to another byte of the granule kills.
        lr(1, 12'h020); step("R1");
        snoop_valid = 1'b1; snoop_addr = 12'h023; step("R3");
        sc(1, 12'h020, 16'h1111); step("R3");
        // R4: last byte of granule matches, first byte of next does not.
        lr(0, 12'h030); step("R1");
        sc(0, 12'h037, 16'h4444); step("R4");
        lr(0, 12'h030); step("R1");
        sc(0, 12'h038, 16'h4545); step("R4");
        // R5: replacement by a second load-reserved.
        lr(2, 12'h040); step("R1");
        lr(2, 12'h050); step("R5");
        sc(2, 12'h040, 16'h5555); step("R5");
        lr(2, 12'h040); step("R1");
        lr(2, 12'h050); step("R5");
        sc(2, 12'h050, 16'h5656); step("R5");
        // R6: clear drops the reservation.
        lr(1, 12'h060); step("R1");
        resv_clear[1] = 1'b1; step("R6");
        sc(1, 12'h060, 16'h6666); step("R6");
        // R7: second conditional store fails.
        lr(0, 12'h070); step("R1");
        sc(0, 12'h070, 16'h7777); step("R7");
        sc(0, 12'h070, 16'h7878); step("R7");
        // R8: a winner kills another requester's reservation.
        lr(0, 12'h080); lr(1, 12'h081); step("R1");
        sc(0, 12'h080, 16'h8888); step("R8");
        sc(1, 12'h081, 16'h8989); step("R8");
        // R9: three-way contention, then a two-way one between 1 and 2.
        lr(0, 12'h0A0); lr(1, 12'h090); lr(2, 12'h092); step("R1");
        sc(0, 12'h0A0, 16'h9000); sc(1, 12'h090, 16'h9001); sc(2, 12'h092, 16'h9002); step("R9");
        lr(1, 12'h090); lr(2, 12'h094); step("R1");
        sc(1, 12'h090, 16'h9101); sc(2, 12'h094, 16'h9102); step("R9");
        // R12: same-cycle events.
        lr(0, 12'h0B0); step("R1");
        sc(0, 12'h0B0, 16'hB0B0); snoop_valid = 1'b1; snoop_addr = 12'h0B4; step("R12");
        lr(1, 12'h0C0); snoop_valid = 1'b1; snoop_addr = 12'h0C0; step("R12");
        sc(1, 12'h0C0, 16'hC0C0); step("R12");
        lr(2, 12'h0D0); step("R1");
        sc(2, 12'h0D0, 16'hD0D0); resv_clear[2] = 1'b1; step("R12");
        // R11: reset in mid-run drops live reservations.
        lr(0, 12'h0E0); lr(1, 12'h0E8); step("R1");
        step("R1");
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1; have_exp = 0;
        for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
        sc(0, 12'h0E0, 16'hE0E0); sc(1, 12'h0E8, 16'hE8E8); step("R11");
        // Random traffic over eight granules.
        for (int k = 0; k < 4000; k++) begin
            for (int i = 0; i < N; i++) begin
                req_valid[i] = ($urandom_range(0, 1) == 1);
                req_op[i]    = ($urandom_range(0, 1) == 1);
                d_addr[i]    = AW'($urandom_range(0, 63));
                d_data[i]    = DW'($urandom);
                resv_clear[i] = ($urandom_range(0, 15) == 0);
            end
            snoop_valid = ($urandom_range(0, 3) == 0);
            snoop_addr  = AW'($urandom_range(0, 63));
            step("R9");
        end
        step("R10");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule